// File: doc/BRIEF.md
# Random Byte Source Host Port

This block sits between a free-running random byte producer and a host that talks over an 8-bit I/O bus with a 10-bit port address. It claims an aligned group of eight port addresses. Inside that group, the host can read the most recent random byte, read a flag that says whether that byte is still unread, and read or write a flag that turns interrupt delivery on or off.

The producer raises a ready strobe whenever it presents a fresh byte. The block stores the byte on the rising edge of that strobe and sets the unread flag. It also returns the unread flag to the producer, so the producer can hold off until the host has taken the previous byte.

When interrupt delivery is on and the unread flag was clear, a fresh byte starts an interrupt. The block turns on the pull-down drive of an open-drain request line for a fixed number of clocks, then switches it off. An external pull-up supplies the rising edge that the interrupt controller responds to. A host that enables interrupts while a byte is already waiting must read that byte once before interrupts resume. A small state machine shapes the pulse:
- **IRQ_IDLE**: the line is released.
- **IRQ_LOW**: the line is driven low for the programmed width.
- **IRQ_REL**: the line is released for at least one clock.

The machine has five transitions:
- *fire*: IRQ_IDLE to IRQ_LOW.
- *width done*: IRQ_LOW to IRQ_REL.
- *rest*: IRQ_REL to IRQ_IDLE.
- *back-to-back*: IRQ_REL to IRQ_LOW, taken for a request that was queued during the pulse or that arrives in IRQ_REL.
- *hold*: IRQ_LOW to IRQ_LOW while the width counter runs.

Top module: `rng_host_port`

## Requirements
- R1: After reset, interrupt enable and the unread flag are 0, the request line is released (`irq_drive_low` = 0), and reads of base+1 and base+2 return 8'h00.
- R2: The block responds only when `bus_addr[9:3]` equals `BASE_ADDR[9:3]`, with BASE_ADDR any multiple of 8 from 10'h000 to 10'h3F8. Outside that group, writes have no effect and `bus_rdata` is 8'h00.
- R3: A write strobe at offset 0 loads interrupt enable from `bus_wdata[0]`, where 1 turns it on and 0 turns it off. A read at offset 2 returns the enable in bit 0, with bits 7..1 read as 0.
- R4: A read strobe at offset 0 returns the stored byte during the same cycle and clears the unread flag at the next clock edge.
- R5: A 0-to-1 change of `src_ready` stores `src_data` and sets the unread flag at the next clock edge. A read at offset 1 returns the flag in bit 0 (bits 7..1 are 0), and `byte_pending` mirrors it. Holding `src_ready` high does not set the flag again after a read.
- R6: Each interrupt drives `irq_drive_low` high for exactly PULSE_CYC clocks, where PULSE_CYC = ceil(IRQ_MIN_NS * CLK_HZ / 1e9). This is 5 clocks for 100 ns at 50 MHz. After the pulse the line is released and never driven high.
- R7: While interrupt enable is 0, `irq_drive_low` stays 0 regardless of producer activity. Enable is sampled as it stood before the clock edge that stores the byte.
- R8: A new byte starts an interrupt only if the unread flag was clear, or was being cleared by an offset-0 read in that same cycle. A byte that arrives while a byte is still pending is stored, but raises no interrupt.
- R9: Offsets 3 to 7 ignore writes, return 8'h00 on reads, and reads there leave the unread flag unchanged.
- R10: If an offset-0 read and a ready rise fall in the same cycle, the read returns the old byte, the new byte is stored, the unread flag ends up set, and an interrupt starts if enabled.
- R11: A qualifying byte that arrives during IRQ_LOW is queued. After the current pulse and exactly one released clock, a second full-width pulse follows, provided enable is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host I/O port address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data; 0 when not an active read of a used port |
| src_data | input | DATA_W | Byte presented by the producer |
| src_ready | input | 1 | Producer ready strobe; the rising edge stores the byte |
| byte_pending | output | 1 | Unread flag returned to the producer |
| irq_drive_low | output | 1 | Pull-down enable for the open-drain request line |

## Verification
The key collision is a host read of offset 0 landing in the same cycle as a ready rise from the producer. In that cycle, a clear of the unread flag and a set of the same flag compete. The bench raises the read strobe and the ready strobe on the same falling edge, with an older byte pending and interrupts enabled. It then judges four outcomes:
- the read data is the old byte;
- the unread flag is still set afterwards;
- a following read yields the new byte;
- exactly one full-width pulse appears.

A second overlap, a qualifying byte arriving while a pulse is still being driven, is judged by counting rising edges and total low clocks on the request line.

// File: rtl/rng_port_pkg.sv
package rng_port_pkg;

    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_LOW  = 2'd1,
        IRQ_REL  = 2'd2
    } irq_state_t;

    // Port offsets inside the decoded group; host software depends on them.
    localparam int unsigned OFS_DATA   = 0;
    localparam int unsigned OFS_STATUS = 1;
    localparam int unsigned OFS_IEN    = 2;

    localparam int unsigned PORT_BITS  = 3;

    // Smallest clock count whose duration reaches min_ns.
    function automatic int unsigned min_cycles(input longint unsigned min_ns,
                                               input longint unsigned clk_hz);
        longint unsigned prod;
        longint unsigned cyc;
        prod = min_ns * clk_hz;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/rng_port_decode.sv
module rng_port_decode #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned PORT_BITS = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
    input  logic [ADDR_W-1:0]           addr,
    output logic [(1<<PORT_BITS)-1:0]   sel
);
    localparam int unsigned NPORTS = 1 << PORT_BITS;

    logic                 group_hit;
    logic [PORT_BITS-1:0] ofs;

    assign group_hit = (addr[ADDR_W-1:PORT_BITS] == BASE_ADDR[ADDR_W-1:PORT_BITS]);
    assign ofs       = addr[PORT_BITS-1:0];

    for (genvar i = 0; i < NPORTS; i++) begin : g_sel
        assign sel[i] = group_hit && (ofs == PORT_BITS'(i));
    end

endmodule

// File: rtl/rng_port_irq_fsm.sv
module rng_port_irq_fsm
    import rng_port_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ien,
    output logic drive_low
);
    localparam int unsigned CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYC - 1);

    irq_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic          queued;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IRQ_IDLE;
        else        state <= nxt;
    end

    // Width counter: preset outside IRQ_LOW, counts down inside it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= CNT_LOAD;
        else if (state != IRQ_LOW)  cnt <= CNT_LOAD;
        else if (cnt != '0)         cnt <= cnt - 1'b1;
    end

    // A request arriving mid-pulse waits for the next pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      queued <= 1'b0;
        else if (state != IRQ_LOW)       queued <= 1'b0;
        else if (fire)                   queued <= 1'b1;
    end

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            IRQ_IDLE: if (fire)            nxt = IRQ_LOW;
            IRQ_LOW:  if (cnt == '0)       nxt = IRQ_REL;
            IRQ_REL:  if (fire || (queued && ien)) nxt = IRQ_LOW;
                      else                 nxt = IRQ_IDLE;
            default:                       nxt = IRQ_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        drive_low = 1'b0;
        unique case (state)
            IRQ_LOW: drive_low = 1'b1;
            default: drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/rng_host_port.sv
module rng_host_port
    import rng_port_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned DATA_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned IRQ_MIN_NS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_ready,
    output logic              byte_pending,
    output logic              irq_drive_low
);
    localparam int unsigned PULSE_CYC = min_cycles(64'(IRQ_MIN_NS), 64'(CLK_HZ));
    localparam int unsigned NPORTS    = 1 << PORT_BITS;

    logic [NPORTS-1:0] sel;
    logic [DATA_W-1:0] data_q;
    logic              ie_q;
    logic              avail_q;
    logic              rdy_q;
    logic              ready_rise;
    logic              rd_data;
    logic              wr_ien;
    logic              fire;

    rng_port_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_BITS (PORT_BITS),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign ready_rise = src_ready && !rdy_q;
    assign rd_data    = bus_rd && sel[OFS_DATA];
    assign wr_ien     = bus_wr && sel[OFS_DATA];
    // A byte counts for an interrupt only if nothing was left unread.
    assign fire       = ready_rise && ie_q && (!avail_q || rd_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= src_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          data_q <= '0;
        else if (ready_rise) data_q <= src_data;
    end

    // Set wins over the read clear when both land together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          avail_q <= 1'b0;
        else if (ready_rise) avail_q <= 1'b1;
        else if (rd_data)    avail_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (wr_ien) ie_q <= bus_wdata[0];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel[OFS_DATA])   bus_rdata = data_q;
            if (sel[OFS_STATUS]) bus_rdata = DATA_W'(avail_q);
            if (sel[OFS_IEN])    bus_rdata = DATA_W'(ie_q);
        end
    end

    assign byte_pending = avail_q;

    rng_port_irq_fsm #(
        .PULSE_CYC (PULSE_CYC)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .ien       (ie_q),
        .drive_low (irq_drive_low)
    );

endmodule

// File: rtl/rng_port_checker.sv
module rng_port_checker #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
    parameter int unsigned PULSE_CYC = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              src_ready,
    input logic              byte_pending,
    input logic              irq_drive_low,
    input logic              ie_q,
    input logic              rdy_q
);
    logic        in_group;
    logic        rd0;
    logic        rise;
    logic [15:0] run_cnt;

    assign in_group = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
    assign rd0      = bus_rd && in_group && (bus_addr[2:0] == 3'd0);
    assign rise     = src_ready && !rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_cnt <= '0;
        else if (irq_drive_low) run_cnt <= run_cnt + 16'd1;
        else                    run_cnt <= '0;
    end

    a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_drive_low) |-> run_cnt == 16'(PULSE_CYC));

    a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_drive_low) |-> $past(ie_q));

    a_r5_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> byte_pending);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !rise) |=> !byte_pending);

    a_r2_offgroup_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_group) |-> bus_rdata == '0);

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && in_group && bus_addr[2:0] > 3'd2) |-> bus_rdata == '0);

    a_r8_fresh_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_drive_low) && !$past(irq_drive_low, 2)) |-> (!$past(byte_pending) || $past(rd0)) || $past(irq_drive_low, 2));

endmodule

bind rng_host_port rng_port_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .src_ready     (src_ready),
    .byte_pending  (byte_pending),
    .irq_drive_low (irq_drive_low),
    .ie_q          (ie_q),
    .rdy_q         (rdy_q)
);

// File: tb/tb_rng_host_port.sv
`timescale 1ns/1ps
module tb_rng_host_port;
    localparam logic [9:0] BASE = 10'h300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] src_data = '0;
    logic       src_ready = 1'b0;
    logic       byte_pending;
    logic       irq_drive_low;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int   rise_cnt = 0;
    int   low_cnt  = 0;
    int   run      = 0;
    int   max_run  = 0;
    logic irq_prev = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rng_host_port #(.BASE_ADDR(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_data(src_data), .src_ready(src_ready),
        .byte_pending(byte_pending), .irq_drive_low(irq_drive_low)
    );

    // Request-line monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_drive_low && !irq_prev) rise_cnt++;
        if (irq_drive_low) begin
            low_cnt++;
            run++;
            if (run > max_run) max_run = run;
        end else begin
            run = 0;
        end
        irq_prev = irq_drive_low;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        @(posedge clk); #1;
        rise_cnt = 0; low_cnt = 0; max_run = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic produce(input logic [7:0] b);
        @(negedge clk); src_data = b; src_ready = 1'b1;
        @(negedge clk); src_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 pending", int'(byte_pending), 0);
        check("R1 irq", int'(irq_drive_low), 0);
        bus_read(BASE + 10'd1, d); check("R1 status", int'(d), 0);
        bus_read(BASE + 10'd2, d); check("R1 enable", int'(d), 0);
    endtask

    task automatic t_enable_rw();
        logic [7:0] d;
        bus_write(BASE, 8'h01);
        bus_read(BASE + 10'd2, d); check("R3 enable set", int'(d), 1);
        bus_write(BASE, 8'hFE);
        bus_read(BASE + 10'd2, d); check("R3 enable clear", int'(d), 0);
    endtask

    task automatic t_poll();
        logic [7:0] d;
        mon_clear();
        produce(8'hA5);
        check("R5 pending set", int'(byte_pending), 1);
        bus_read(BASE + 10'd1, d); check("R5 status", int'(d), 1);
        idle(8);
        check("R7 no pulse while disabled", rise_cnt, 0);
        bus_read(BASE, d); check("R4 data", int'(d), 8'hA5);
        check("R4 pending cleared", int'(byte_pending), 0);
        bus_read(BASE + 10'd1, d); check("R4 status cleared", int'(d), 0);
    endtask

    task automatic t_level_hold();
        logic [7:0] d;
        @(negedge clk); src_data = 8'h3C; src_ready = 1'b1;
        idle(2);
        bus_read(BASE, d); check("R5 held level data", int'(d), 8'h3C);
        idle(3);
        check("R5 no re-set on level", int'(byte_pending), 0);
        @(negedge clk); src_ready = 1'b0;
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        bus_write(BASE, 8'h01);
        mon_clear();
        produce(8'h5A);
        check("R6 line low after byte", int'(irq_drive_low), 1);
        idle(10);
        check("R6 one pulse", rise_cnt, 1);
        check("R6 width", max_run, 5);
        check("R6 released", int'(irq_drive_low), 0);
        bus_read(BASE, d); check("R6 data", int'(d), 8'h5A);
        bus_write(BASE, 8'h00);
    endtask

    task automatic t_prime();
        logic [7:0] d;
        produce(8'h11);
        bus_write(BASE, 8'h01);
        mon_clear();
        produce(8'h22);
        idle(10);
        check("R8 no pulse while pending", rise_cnt, 0);
        bus_read(BASE, d); check("R8 latest byte", int'(d), 8'h22);
        mon_clear();
        produce(8'h33);
        idle(10);
        check("R8 pulse after priming read", rise_cnt, 1);
        bus_read(BASE, d); check("R8 data", int'(d), 8'h33);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        produce(8'h44);
        idle(10);
        mon_clear();
        @(negedge clk);
        bus_addr = BASE; bus_rd = 1'b1; src_data = 8'h55; src_ready = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; src_ready = 1'b0;
        check("R10 old byte returned", int'(d), 8'h44);
        check("R10 pending stays set", int'(byte_pending), 1);
        check("R10 pulse started", int'(irq_drive_low), 1);
        idle(10);
        check("R10 one pulse", rise_cnt, 1);
        bus_read(BASE, d); check("R10 new byte", int'(d), 8'h55);
    endtask

    task automatic t_queue();
        logic [7:0] d;
        mon_clear();
        produce(8'h66);
        bus_read(BASE, d);
        check("R11 first byte", int'(d), 8'h66);
        produce(8'h77);
        idle(14);
        check("R11 two pulses", rise_cnt, 2);
        check("R11 total low", low_cnt, 10);
        check("R11 width", max_run, 5);
        bus_read(BASE, d); check("R11 second byte", int'(d), 8'h77);
        bus_write(BASE, 8'h00);
    endtask

    task automatic t_unused();
        logic [7:0] d;
        produce(8'h99);
        for (int o = 3; o < 8; o++) begin
            bus_write(BASE + 10'(o), 8'hFF);
            bus_read(BASE + 10'(o), d);
            check("R9 unused reads zero", int'(d), 0);
        end
        check("R9 pending untouched", int'(byte_pending), 1);
        bus_read(BASE + 10'd2, d); check("R9 enable untouched", int'(d), 0);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        bus_read(10'h2F8, d); check("R2 below group", int'(d), 0);
        bus_read(10'h308, d); check("R2 above group", int'(d), 0);
        bus_read(10'h000, d); check("R2 far address", int'(d), 0);
        check("R2 pending untouched", int'(byte_pending), 1);
        bus_write(10'h308, 8'h01);
        bus_read(BASE + 10'd2, d); check("R2 enable untouched", int'(d), 0);
        bus_read(BASE, d); check("R2 in-group data", int'(d), 8'h99);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_enable_rw();
        t_poll();
        t_level_hold();
        t_pulse();
        t_prime();
        t_same_cycle();
        t_queue();
        t_unused();
        t_decode();
        idle(4);
        finish_run();
    end

endmodule